// File: doc/BRIEF.md
# Display controller register access port

This unit sits between a CPU's byte-wide I/O window and the configuration state of a display controller. It decodes a 5-bit offset within the window and holds several banks of byte registers: four ordinary banks (sequencer, graphics, CRT timing, extended), an attribute bank, a colour palette, a palette mask and a miscellaneous output byte. Every stored value is brought out on flat output vectors for the rest of the controller to use.

Each ordinary bank is reached through a pair of ports: an index port, then a data port one offset above it. The attribute bank has only one write offset. A phase flip-flop decides whether a write there loads the index or stores data, and each write flips it. A read of the second status offset forces the flip-flop back to index phase, which lets software resynchronise without knowing the current phase. The palette takes colour triplets through one data port. A sub-counter steps red, green, blue, and after blue the entry index advances.

Reads and writes have separate address buses, so the same cycle can hold a read and a write. A read has a side effect only at the status-1 offset.

Top module: `dspio_regs`

## Requirements
- R1: Every ordinary bank has its index port at an even offset (sequencer 0x04, graphics 0x0E, CRT 0x14, extended 0x16) and its data port at that offset plus one. A data write stores into the indexed entry. Reads return the index and the entry, and entry k is visible on bits [8k+7:8k] of the bank's output vector.
- R2: Writes to attribute offset 0x00 alternate: one loads the index, the next stores into the indexed attribute entry, and so on. A read at 0x01 returns the indexed attribute entry.
- R3: A read at offset 0x1A returns `stat1_i` and leaves the attribute phase at index, so the next attribute write is an index. If an attribute write falls in the same cycle, that write is handled in the phase that held before the edge.
- R4: An attribute index write stores bits [4:0] as the index and bit 5 as `video_en_o`. A read at 0x00 returns {2'b00, video enable, index}.
- R5: A write at offset 0x02 loads `misc_o`. A read at 0x02 returns `stat0_i`, and a read at 0x0C returns the stored miscellaneous byte.
- R6: Three writes to palette data offset 0x09 store red, green and blue of the entry at the palette index. Entry k sits at bits [24k+23:24k] of `pal_o`, with red in the top byte and blue in the bottom byte.
- R7: After the blue write, the palette index (offset 0x08, readable) increments by one and the sub-counter returns to red. An index write also restarts at red. A read at 0x09 returns the component that the next write would replace, and it does not advance.
- R8: A bank index at or beyond the bank's depth reads as zero at its data port, and data writes to it change no output. The index itself still reads back in full.
- R9: After reset, every register, index, enable, palette sub-counter and the attribute phase is zero, so the first attribute write is an index.
- R10: `rd_data_o` is zero while `rd_i` is low and for any unmapped read offset.
- R11: Offset 0x06 is a read/write palette mask byte shown on `pal_mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe |
| wr_addr_i | input | 5 | Write offset |
| wr_data_i | input | 8 | Write byte |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | 5 | Read offset |
| rd_data_o | output | 8 | Read byte (combinational) |
| stat0_i | input | 8 | Status byte returned at read offset 0x02 |
| stat1_i | input | 8 | Status byte returned at read offset 0x1A |
| misc_o | output | 8 | Miscellaneous output byte (sync polarity, clock select) |
| video_en_o | output | 1 | Video enable from the attribute index port |
| attr_regs_o | output | ATTR_N*8 | Attribute entries |
| seq_regs_o | output | SEQ_N*8 | Sequencer entries |
| gfx_regs_o | output | GFX_N*8 | Graphics entries |
| crt_regs_o | output | CRT_N*8 | CRT timing entries |
| ext_regs_o | output | EXT_N*8 | Extended entries |
| pal_mask_o | output | 8 | Palette mask |
| pal_o | output | PAL_N*24 | Palette entries, RGB |

## Verification
The case of interest is a status-1 read and an attribute write in the same cycle, which the split read and write buses allow. The bench first leaves the phase at data by writing an attribute index. It then issues the read at 0x1A and a write at 0x00 in one cycle. The write must land as data in the previously indexed entry, and the following write must be taken as a new index, as shown by the index readback and the attribute output vector. A second overlap is a palette data read in the cycle a palette write advances. The read must show the component as it was before the edge.

// File: rtl/dspio_pkg.sv
package dspio_pkg;
  localparam int unsigned AW = 5;
  typedef logic [AW-1:0] ioaddr_t;

  localparam ioaddr_t OFS_ATTR    = 5'h00;
  localparam ioaddr_t OFS_ATTR_RD = 5'h01;
  localparam ioaddr_t OFS_MISC_W  = 5'h02;  // read: status 0
  localparam ioaddr_t OFS_SEQ_I   = 5'h04;
  localparam ioaddr_t OFS_SEQ_D   = 5'h05;
  localparam ioaddr_t OFS_PMASK   = 5'h06;
  localparam ioaddr_t OFS_PIDX    = 5'h08;
  localparam ioaddr_t OFS_PDATA   = 5'h09;
  localparam ioaddr_t OFS_MISC_R  = 5'h0C;
  localparam ioaddr_t OFS_GFX_I   = 5'h0E;
  localparam ioaddr_t OFS_GFX_D   = 5'h0F;
  localparam ioaddr_t OFS_CRT_I   = 5'h14;
  localparam ioaddr_t OFS_CRT_D   = 5'h15;
  localparam ioaddr_t OFS_EXT_I   = 5'h16;
  localparam ioaddr_t OFS_EXT_D   = 5'h17;
  localparam ioaddr_t OFS_STAT1   = 5'h1A;

  typedef enum logic [1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2
  } colour_e;
endpackage

// File: rtl/dspio_idx_bank.sv
module dspio_idx_bank #(
  parameter int unsigned N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           idx_we_i,
  input  logic           dat_we_i,
  input  logic [7:0]     wdata_i,
  output logic [7:0]     idx_o,
  output logic [7:0]     dat_o,
  output logic [N*8-1:0] regs_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [7:0] idx_q;
  logic [7:0] mem_q [N];
  logic       hit;

  assign hit = 32'(idx_q) < N;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i;
  end

  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[k] <= '0;
      else if (dat_we_i && hit && idx_q[IW-1:0] == IW'(k)) mem_q[k] <= wdata_i;
    end
    assign regs_o[k*8 +: 8] = mem_q[k];
  end

  assign idx_o = idx_q;
  assign dat_o = hit ? mem_q[idx_q[IW-1:0]] : 8'h00;

  a_r8_oob_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i && !hit |=> $stable(regs_o));

  a_r1_data_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i && !idx_we_i && hit |=> dat_o == $past(wdata_i));
endmodule

// File: rtl/dspio_attr_bank.sv
module dspio_attr_bank #(
  parameter int unsigned N = 21
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           clr_i,
  input  logic [7:0]     wdata_i,
  output logic [4:0]     idx_o,
  output logic           video_o,
  output logic [7:0]     dat_o,
  output logic [N*8-1:0] regs_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [4:0] idx_q;
  logic       video_q;
  logic       data_ph_q;  // 0: next write is index
  logic [7:0] mem_q [N];
  logic       hit;
  logic       idx_wr, dat_wr;

  assign hit    = 32'(idx_q) < N;
  assign idx_wr = wr_i && !data_ph_q;
  assign dat_wr = wr_i && data_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_ph_q <= 1'b0;
    else if (clr_i) data_ph_q <= 1'b0;
    else if (wr_i)  data_ph_q <= ~data_ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      video_q <= 1'b0;
    end else if (idx_wr) begin
      idx_q   <= wdata_i[4:0];
      video_q <= wdata_i[5];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[k] <= '0;
      else if (dat_wr && hit && idx_q[IW-1:0] == IW'(k)) mem_q[k] <= wdata_i;
    end
    assign regs_o[k*8 +: 8] = mem_q[k];
  end

  assign idx_o   = idx_q;
  assign video_o = video_q;
  assign dat_o   = hit ? mem_q[idx_q[IW-1:0]] : 8'h00;

  a_r3_clear_to_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !data_ph_q);

  a_r2_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i |=> data_ph_q != $past(data_ph_q));

  a_r4_video_from_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !data_ph_q |=> video_o == $past(wdata_i[5]));

  a_r8_attr_oob_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && data_ph_q && !hit |=> $stable(regs_o));
endmodule

// File: rtl/dspio_palette.sv
module dspio_palette
  import dspio_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mask_we_i,
  input  logic            idx_we_i,
  input  logic            dat_we_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      idx_o,
  output logic [7:0]      mask_o,
  output logic [7:0]      dat_o,
  output logic [N*24-1:0] pal_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [7:0] idx_q, mask_q;
  colour_e    sub_q;
  logic [7:0] red_q [N];
  logic [7:0] grn_q [N];
  logic [7:0] blu_q [N];
  logic       hit;
  logic [IW-1:0] sel;

  assign hit = 32'(idx_q) < N;
  assign sel = idx_q[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      sub_q  <= COL_RED;
      mask_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      if (idx_we_i) begin
        idx_q <= wdata_i;
        sub_q <= COL_RED;
      end else if (dat_we_i) begin
        unique case (sub_q)
          COL_RED:   sub_q <= COL_GREEN;
          COL_GREEN: sub_q <= COL_BLUE;
          default: begin
            sub_q <= COL_RED;
            idx_q <= idx_q + 8'd1;
          end
        endcase
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_ent
    logic wsel;
    assign wsel = dat_we_i && !idx_we_i && hit && sel == IW'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        red_q[k] <= '0;
        grn_q[k] <= '0;
        blu_q[k] <= '0;
      end else if (wsel) begin
        if (sub_q == COL_RED)   red_q[k] <= wdata_i;
        if (sub_q == COL_GREEN) grn_q[k] <= wdata_i;
        if (sub_q == COL_BLUE)  blu_q[k] <= wdata_i;
      end
    end
    assign pal_o[k*24 +: 24] = {red_q[k], grn_q[k], blu_q[k]};
  end

  always_comb begin
    dat_o = 8'h00;
    if (hit) begin
      unique case (sub_q)
        COL_RED:   dat_o = red_q[sel];
        COL_GREEN: dat_o = grn_q[sel];
        default:   dat_o = blu_q[sel];
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign mask_o = mask_q;

  a_r7_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i && !idx_we_i && sub_q == COL_BLUE |=>
      sub_q == COL_RED && idx_q == $past(idx_q) + 8'd1);

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_i |=> sub_q == COL_RED && idx_q == $past(wdata_i));

  a_r7_sub_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q != 2'd3);
endmodule

// File: rtl/dspio_regs.sv
module dspio_regs
  import dspio_pkg::*;
#(
  parameter int unsigned ATTR_N = 21,
  parameter int unsigned SEQ_N  = 8,
  parameter int unsigned GFX_N  = 16,
  parameter int unsigned CRT_N  = 128,
  parameter int unsigned EXT_N  = 64,
  parameter int unsigned PAL_N  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [4:0]          wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic                rd_i,
  input  logic [4:0]          rd_addr_i,
  output logic [7:0]          rd_data_o,
  input  logic [7:0]          stat0_i,
  input  logic [7:0]          stat1_i,
  output logic [7:0]          misc_o,
  output logic                video_en_o,
  output logic [ATTR_N*8-1:0] attr_regs_o,
  output logic [SEQ_N*8-1:0]  seq_regs_o,
  output logic [GFX_N*8-1:0]  gfx_regs_o,
  output logic [CRT_N*8-1:0]  crt_regs_o,
  output logic [EXT_N*8-1:0]  ext_regs_o,
  output logic [7:0]          pal_mask_o,
  output logic [PAL_N*24-1:0] pal_o
);
  function automatic logic wr_at(input logic s, input ioaddr_t a, input ioaddr_t o);
    return s && (a == o);
  endfunction

  logic [7:0] misc_q;
  logic [7:0] seq_idx, seq_dat, gfx_idx, gfx_dat, crt_idx, crt_dat, ext_idx, ext_dat;
  logic [4:0] attr_idx;
  logic [7:0] attr_dat, pal_idx, pal_dat;
  logic       stat1_rd;

  assign stat1_rd = wr_at(rd_i, rd_addr_i, OFS_STAT1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) misc_q <= '0;
    else if (wr_at(wr_i, wr_addr_i, OFS_MISC_W)) misc_q <= wr_data_i;
  end
  assign misc_o = misc_q;

  dspio_idx_bank #(.N(SEQ_N)) i_seq (
    .clk_i, .rst_ni,
    .idx_we_i (wr_at(wr_i, wr_addr_i, OFS_SEQ_I)),
    .dat_we_i (wr_at(wr_i, wr_addr_i, OFS_SEQ_D)),
    .wdata_i  (wr_data_i),
    .idx_o    (seq_idx),
    .dat_o    (seq_dat),
    .regs_o   (seq_regs_o)
  );

  dspio_idx_bank #(.N(GFX_N)) i_gfx (
    .clk_i, .rst_ni,
    .idx_we_i (wr_at(wr_i, wr_addr_i, OFS_GFX_I)),
    .dat_we_i (wr_at(wr_i, wr_addr_i, OFS_GFX_D)),
    .wdata_i  (wr_data_i),
    .idx_o    (gfx_idx),
    .dat_o    (gfx_dat),
    .regs_o   (gfx_regs_o)
  );

  dspio_idx_bank #(.N(CRT_N)) i_crt (
    .clk_i, .rst_ni,
    .idx_we_i (wr_at(wr_i, wr_addr_i, OFS_CRT_I)),
    .dat_we_i (wr_at(wr_i, wr_addr_i, OFS_CRT_D)),
    .wdata_i  (wr_data_i),
    .idx_o    (crt_idx),
    .dat_o    (crt_dat),
    .regs_o   (crt_regs_o)
  );

  dspio_idx_bank #(.N(EXT_N)) i_ext (
    .clk_i, .rst_ni,
    .idx_we_i (wr_at(wr_i, wr_addr_i, OFS_EXT_I)),
    .dat_we_i (wr_at(wr_i, wr_addr_i, OFS_EXT_D)),
    .wdata_i  (wr_data_i),
    .idx_o    (ext_idx),
    .dat_o    (ext_dat),
    .regs_o   (ext_regs_o)
  );

  dspio_attr_bank #(.N(ATTR_N)) i_attr (
    .clk_i, .rst_ni,
    .wr_i    (wr_at(wr_i, wr_addr_i, OFS_ATTR)),
    .clr_i   (stat1_rd),
    .wdata_i (wr_data_i),
    .idx_o   (attr_idx),
    .video_o (video_en_o),
    .dat_o   (attr_dat),
    .regs_o  (attr_regs_o)
  );

  dspio_palette #(.N(PAL_N)) i_pal (
    .clk_i, .rst_ni,
    .mask_we_i (wr_at(wr_i, wr_addr_i, OFS_PMASK)),
    .idx_we_i  (wr_at(wr_i, wr_addr_i, OFS_PIDX)),
    .dat_we_i  (wr_at(wr_i, wr_addr_i, OFS_PDATA)),
    .wdata_i   (wr_data_i),
    .idx_o     (pal_idx),
    .mask_o    (pal_mask_o),
    .dat_o     (pal_dat),
    .pal_o     (pal_o)
  );

  always_comb begin
    rd_data_o = 8'h00;
    if (rd_i) begin
      unique case (rd_addr_i)
        OFS_ATTR:    rd_data_o = {2'b00, video_en_o, attr_idx};
        OFS_ATTR_RD: rd_data_o = attr_dat;
        OFS_MISC_W:  rd_data_o = stat0_i;
        OFS_SEQ_I:   rd_data_o = seq_idx;
        OFS_SEQ_D:   rd_data_o = seq_dat;
        OFS_PMASK:   rd_data_o = pal_mask_o;
        OFS_PIDX:    rd_data_o = pal_idx;
        OFS_PDATA:   rd_data_o = pal_dat;
        OFS_MISC_R:  rd_data_o = misc_q;
        OFS_GFX_I:   rd_data_o = gfx_idx;
        OFS_GFX_D:   rd_data_o = gfx_dat;
        OFS_CRT_I:   rd_data_o = crt_idx;
        OFS_CRT_D:   rd_data_o = crt_dat;
        OFS_EXT_I:   rd_data_o = ext_idx;
        OFS_EXT_D:   rd_data_o = ext_dat;
        OFS_STAT1:   rd_data_o = stat1_i;
        default:     rd_data_o = 8'h00;
      endcase
    end
  end

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rd_data_o == 8'h00);

  a_r5_misc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_addr_i == OFS_MISC_W |=> misc_o == $past(wr_data_i));
endmodule

// File: tb/test_dspio_regs.sv
module test_dspio_regs;
  localparam time CLK_P = 10ns;
  localparam int unsigned ATTR_N = 21, SEQ_N = 8, GFX_N = 16, CRT_N = 128, EXT_N = 64, PAL_N = 16;

  typedef struct packed {
    logic       rd;
    logic [4:0] addr;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VT [NV] = '{
    '{1'b0, 5'h04, 8'h02, 4'd1},  // R1 seq index 2
    '{1'b0, 5'h05, 8'hA5, 4'd1},  // R1
    '{1'b1, 5'h04, 8'h02, 4'd1},  // R1
    '{1'b1, 5'h05, 8'hA5, 4'd1},  // R1
    '{1'b0, 5'h0E, 8'h07, 4'd1},  // R1 graphics
    '{1'b0, 5'h0F, 8'h3C, 4'd1},  // R1
    '{1'b1, 5'h0F, 8'h3C, 4'd1},  // R1
    '{1'b0, 5'h14, 8'h11, 4'd1},  // R1 crt
    '{1'b0, 5'h15, 8'h5A, 4'd1},  // R1
    '{1'b1, 5'h15, 8'h5A, 4'd1},  // R1
    '{1'b0, 5'h16, 8'h20, 4'd1},  // R1 extended
    '{1'b0, 5'h17, 8'h99, 4'd1},  // R1
    '{1'b1, 5'h17, 8'h99, 4'd1},  // R1
    '{1'b1, 5'h05, 8'hA5, 4'd1},  // R1 banks independent
    '{1'b0, 5'h04, 8'h09, 4'd8},  // R8 index past depth
    '{1'b0, 5'h05, 8'hFF, 4'd8},  // R8
    '{1'b1, 5'h05, 8'h00, 4'd8},  // R8
    '{1'b1, 5'h04, 8'h09, 4'd8},  // R8
    '{1'b1, 5'h1A, 8'h09, 4'd10}, // R10 status 1
    '{1'b0, 5'h00, 8'h03, 4'd2},  // R2 index
    '{1'b0, 5'h00, 8'h77, 4'd2},  // R2 data
    '{1'b1, 5'h00, 8'h03, 4'd2},  // R2
    '{1'b1, 5'h01, 8'h77, 4'd2},  // R2
    '{1'b0, 5'h00, 8'h25, 4'd4},  // R4 index 5 + video
    '{1'b1, 5'h00, 8'h25, 4'd4},  // R4
    '{1'b0, 5'h00, 8'h44, 4'd2},  // R2
    '{1'b1, 5'h01, 8'h44, 4'd2},  // R2
    '{1'b0, 5'h00, 8'h06, 4'd3},  // R3 index, phase now data
    '{1'b1, 5'h1A, 8'h09, 4'd3},  // R3 clears phase
    '{1'b0, 5'h00, 8'h08, 4'd3},  // R3 taken as index
    '{1'b1, 5'h00, 8'h08, 4'd3},  // R3
    '{1'b1, 5'h01, 8'h00, 4'd3},  // R3
    '{1'b0, 5'h02, 8'hC3, 4'd5},  // R5
    '{1'b1, 5'h02, 8'h60, 4'd5},  // R5 status 0
    '{1'b1, 5'h0C, 8'hC3, 4'd5},  // R5
    '{1'b0, 5'h06, 8'hF0, 4'd11}, // R11
    '{1'b1, 5'h06, 8'hF0, 4'd11}, // R11
    '{1'b0, 5'h08, 8'h03, 4'd7},  // R7
    '{1'b0, 5'h09, 8'h11, 4'd6},  // R6 red
    '{1'b0, 5'h09, 8'h22, 4'd6},  // R6 green
    '{1'b1, 5'h09, 8'h00, 4'd7},  // R7 blue pending
    '{1'b0, 5'h09, 8'h33, 4'd6},  // R6 blue
    '{1'b1, 5'h08, 8'h04, 4'd7},  // R7 advanced
    '{1'b1, 5'h09, 8'h00, 4'd7},  // R7 red of entry 4
    '{1'b0, 5'h08, 8'h03, 4'd7},  // R7
    '{1'b1, 5'h09, 8'h11, 4'd6},  // R6
    '{1'b1, 5'h09, 8'h11, 4'd7},  // R7 no advance on read
    '{1'b1, 5'h10, 8'h00, 4'd10}, // R10 unmapped
    '{1'b1, 5'h1A, 8'h09, 4'd10}  // R10
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [4:0] waddr = '0, raddr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] stat0 = 8'h60, stat1 = 8'h09;
  logic [7:0] misc, pmask;
  logic video_en;
  logic [ATTR_N*8-1:0] attr_regs;
  logic [SEQ_N*8-1:0]  seq_regs;
  logic [GFX_N*8-1:0]  gfx_regs;
  logic [CRT_N*8-1:0]  crt_regs;
  logic [EXT_N*8-1:0]  ext_regs;
  logic [PAL_N*24-1:0] pal;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  dspio_regs i_dspio_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_i(wr), .wr_addr_i(waddr), .wr_data_i(wdata),
    .rd_i(rd), .rd_addr_i(raddr), .rd_data_o(rdata),
    .stat0_i(stat0), .stat1_i(stat1),
    .misc_o(misc), .video_en_o(video_en),
    .attr_regs_o(attr_regs), .seq_regs_o(seq_regs), .gfx_regs_o(gfx_regs),
    .crt_regs_o(crt_regs), .ext_regs_o(ext_regs),
    .pal_mask_o(pmask), .pal_o(pal)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; waddr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd = 1'b1; raddr = a;
    #1 check(64'(rdata), 64'(e), tag);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic do_both(input logic [4:0] wa, input logic [7:0] d,
                         input logic [4:0] ra, input logic [7:0] e, input string tag);
    @(negedge clk);
    wr = 1'b1; waddr = wa; wdata = d;
    rd = 1'b1; raddr = ra;
    #1 check(64'(rdata), 64'(e), tag);
    @(posedge clk); #1;
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [ATTR_N*8-1:0] attr_snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    do_rd(5'h04, 8'h00, "R9 seq index");
    do_rd(5'h00, 8'h00, "R9 attr index");
    check(64'(misc), 64'h0, "R9 misc");
    check(64'(video_en), 64'h0, "R9 video");
    check(64'(pal_o_any()), 64'h0, "R9 palette");
    check(64'(|attr_regs), 64'h0, "R9 attr regs");
    do_wr(5'h00, 8'h02);
    do_rd(5'h00, 8'h02, "R9 first attr write is index");
    do_wr(5'h09, 8'hAB);
    check(64'(pal[23:16]), 64'hAB, "R9 sub-counter starts at red");

    for (int i = 0; i < NV; i++) begin
      if (VT[i].rd) do_rd(VT[i].addr, VT[i].data, $sformatf("R%0d vec%0d", VT[i].req, i));
      else          do_wr(VT[i].addr, VT[i].data);
    end

    check(seq_regs, 64'h0000_0000_00A5_0000, "R8 seq vector untouched by oob write");
    check(64'(gfx_regs[7*8 +: 8]), 64'h3C, "R1 gfx vector");
    check(64'(crt_regs[8'h11*8 +: 8]), 64'h5A, "R1 crt vector");
    check(64'(ext_regs[8'h20*8 +: 8]), 64'h99, "R1 ext vector");
    check(64'(attr_regs[3*8 +: 8]), 64'h77, "R2 attr entry 3");
    check(64'(attr_regs[5*8 +: 8]), 64'h44, "R2 attr entry 5");
    check(64'(pal[3*24 +: 24]), 64'h112233, "R6 palette entry 3");
    check(64'(misc), 64'hC3, "R5 misc output");
    check(64'(pmask), 64'hF0, "R11 mask output");
    check(64'(video_en), 64'h0, "R4 video cleared by index 0x08");

    // R3 status read and attr data write in one cycle
    do_wr(5'h00, 8'h07);
    do_both(5'h00, 8'h5E, 5'h1A, 8'h09, "R3 same-cycle status read");
    check(64'(attr_regs[7*8 +: 8]), 64'h5E, "R3 write kept data phase");
    do_wr(5'h00, 8'h0A);
    do_rd(5'h00, 8'h0A, "R3 next write was index");

    // R4 video enable
    do_rd(5'h1A, 8'h09, "R4 resync");
    do_wr(5'h00, 8'h20);
    check(64'(video_en), 64'h1, "R4 video enable set");
    do_rd(5'h00, 8'h20, "R4 index readback");

    // R8 attribute index past depth
    do_rd(5'h1A, 8'h09, "R8 resync");
    do_wr(5'h00, 8'h3F);
    attr_snap = attr_regs;
    do_wr(5'h00, 8'hEE);
    check(64'(attr_regs == attr_snap), 64'h1, "R8 attr oob write ignored");
    do_rd(5'h01, 8'h00, "R8 attr oob reads zero");

    // R7 read in the cycle a palette write advances
    do_wr(5'h08, 8'h05);
    do_wr(5'h09, 8'h01);
    do_wr(5'h09, 8'h02);
    do_both(5'h09, 8'h03, 5'h09, 8'h00, "R7 read sees pre-edge blue");
    do_rd(5'h08, 8'h06, "R7 index after overlap");

    // R10 idle read strobe
    @(negedge clk);
    raddr = 5'h05; rd = 1'b0;
    #1 check(64'(rdata), 64'h0, "R10 idle read data");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic pal_o_any();
    return |pal;
  endfunction
endmodule